// File: doc/BRIEF.md
# Dual-Lane Framed Serial Sample Port

This block moves baseband sample pairs from the filter chain to a signal processor over a synchronous serial link. The filter chain presents one I/Q pair for branch A and one for branch B together with a valid strobe. The port loads both pairs into two 32-bit shifters and sends them on two data lanes in lockstep, most significant bit first. The I word goes first and the Q word follows with no gap. One frame-sync output serves both lanes and marks the start of each 16-bit word.

The port accepts a new pair only while it is idle. A pair offered while a frame is in flight is dropped, and a sticky overrun flag records the loss. In single-stream mode the second lane stays at zero for the whole frame. A receive shifter on the same clock watches a frame-sync input. After each sync it gathers the next 16 data-input bits and presents them as one word with a one-cycle valid pulse.

Top module: `serial_pair_port`

## Requirements
- R1: After reset, frame sync and both lanes are 0, the ready output is 1, overrun is 0 and the receive valid is 0.
- R2: A pair is taken at a clock edge where both valid and ready are high. Ready is low for the 33 cycles after that edge (one sync cycle and 32 bit cycles) and is high again in the cycle after.
- R3: Frame sync is a one-cycle pulse. It is high in the first cycle after acceptance, which is the cycle before I bit 15. It is high again in the cycle that carries I bit 0, which is the cycle before Q bit 15. It is low at all other times.
- R4: Lane 0 carries branch-A I bits 15 down to 0 and then branch-A Q bits 15 down to 0, one bit per cycle, in the 32 cycles after the sync cycle.
- R5: Lane 1 carries branch-B I and then Q, with the same ordering and in the same cycles as lane 0.
- R6: When the single-stream input is 1 at acceptance, lane 1 stays 0 for the whole frame, and lane 0 is unaffected.
- R7: A valid offered while ready is low sets the overrun output, which then stays 1 until reset. The offered pair is ignored, and the frame in flight continues unchanged.
- R8: Both lanes are 0 in the sync cycle and whenever the port is idle.
- R9: After a clock edge that samples frame-sync input high, the next 16 data-input bits are assembled MSB first. The word appears on the receive word output, with a one-cycle receive valid, in the cycle after the 16th bit is sampled.
- R10: A frame-sync input sampled during a partial word discards the bits gathered so far and restarts the count. No valid is raised for the abandoned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| pairValid | input | 1 | Sample pair offered by the filter chain |
| pairReady | output | 1 | Port idle, a pair will be accepted |
| singleStream | input | 1 | 1: lane 1 held at zero for the frame |
| aI | input | 16 | Branch-A in-phase sample |
| aQ | input | 16 | Branch-A quadrature sample |
| bI | input | 16 | Branch-B in-phase sample |
| bQ | input | 16 | Branch-B quadrature sample |
| fsOut | output | 1 | Frame-sync output pulse |
| lane0 | output | 1 | Serial data, branch A |
| lane1 | output | 1 | Serial data, branch B |
| overrun | output | 1 | Sticky lost-pair flag |
| fsIn | input | 1 | Receive frame-sync input |
| dIn | input | 1 | Receive serial data input |
| rxWord | output | 16 | Last received word |
| rxValid | output | 1 | One-cycle pulse with a new word |

## Verification
If the frame counter is off by one, the sync pulse moves relative to bit 15. The error appears at the pins in the first cycle after acceptance, and a bit-by-bit capture of both lanes catches it. A counter that goes wrong between the words shows up on the second sync pulse, or as an I/Q boundary that sits one bit off. A shifter that reloads when it should not shows up as corrupted bits within the same frame, which matters most when a pair is offered mid-frame. Looping the transmit pins back into the receiver exposes any receive count error on the very next word, either as a wrong word value or as a missing or extra valid pulse.

// File: rtl/serial_pair_pkg.sv
package serial_pair_pkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic drive;
  } txStrobe_t;
endpackage

// File: rtl/serial_pair_ctrl.sv
module serial_pair_ctrl
  import serial_pair_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pairValid,
  output logic      pairReady,
  output logic      fsOut,
  output logic      overrun,
  output txStrobe_t strb
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] SYNC_A = CNT_W'(1);
  localparam logic [CNT_W-1:0] SYNC_B = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] FIRST  = CNT_W'(2);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0] phase;
  logic             idle;

  assign idle = (phase == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      overrun <= 1'b0;
    end else begin
      if (pairValid && !idle) overrun <= 1'b1;
      if (idle) begin
        if (pairValid) phase <= SYNC_A;
      end else if (phase == LAST) begin
        phase <= '0;
      end else begin
        phase <= phase + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strb.load  = pairValid && idle;
    strb.drive = (phase >= FIRST);
    strb.shift = (phase >= FIRST);
  end

  assign pairReady = idle;
  assign fsOut     = (phase == SYNC_A) || (phase == SYNC_B);
endmodule

// File: rtl/serial_pair_dp.sv
module serial_pair_dp
  import serial_pair_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  txStrobe_t             strb,
  input  logic                  singleStream,
  input  logic [WORD_W-1:0]     wordI [LANES],
  input  logic [WORD_W-1:0]     wordQ [LANES],
  output logic [LANES-1:0]      laneOut
);
  localparam int FRAME_W = 2 * WORD_W;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [FRAME_W-1:0] shiftReg;
    logic               keep;

    if (ln == 0) begin : g_primary
      assign keep = 1'b1;
    end else begin : g_secondary
      assign keep = !singleStream;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftReg <= '0;
      end else if (strb.load) begin
        shiftReg <= keep ? {wordI[ln], wordQ[ln]} : '0;
      end else if (strb.shift) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      end
    end

    assign laneOut[ln] = strb.drive & shiftReg[FRAME_W-1];
  end
endmodule

// File: rtl/serial_pair_rx.sv
module serial_pair_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsIn,
  input  logic              dIn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  localparam int RC_W = $clog2(WORD_W + 1);
  localparam logic [RC_W-1:0] FULL = RC_W'(WORD_W);

  logic [RC_W-1:0]   remain;
  logic [WORD_W-1:0] gather;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain  <= '0;
      gather  <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (remain != '0) begin
        gather <= {gather[WORD_W-2:0], dIn};
        remain <= remain - RC_W'(1);
        if (remain == RC_W'(1)) begin
          rxWord  <= {gather[WORD_W-2:0], dIn};
          rxValid <= 1'b1;
        end
      end
      if (fsIn) begin
        remain <= FULL;
        if (remain != RC_W'(1)) rxValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_pair_port.sv
module serial_pair_port
  import serial_pair_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pairValid,
  output logic              pairReady,
  input  logic              singleStream,
  input  logic [WORD_W-1:0] aI,
  input  logic [WORD_W-1:0] aQ,
  input  logic [WORD_W-1:0] bI,
  input  logic [WORD_W-1:0] bQ,
  output logic              fsOut,
  output logic              lane0,
  output logic              lane1,
  output logic              overrun,
  input  logic              fsIn,
  input  logic              dIn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  localparam int LANES = 2;

  txStrobe_t         strb;
  logic [WORD_W-1:0] wordI [LANES];
  logic [WORD_W-1:0] wordQ [LANES];
  logic [LANES-1:0]  laneOut;

  assign wordI[0] = aI;
  assign wordQ[0] = aQ;
  assign wordI[1] = bI;
  assign wordQ[1] = bQ;

  serial_pair_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pairValid(pairValid), .pairReady(pairReady),
    .fsOut(fsOut), .overrun(overrun), .strb(strb)
  );

  serial_pair_dp #(.WORD_W(WORD_W), .LANES(LANES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .singleStream(singleStream),
    .wordI(wordI), .wordQ(wordQ), .laneOut(laneOut)
  );

  serial_pair_rx #(.WORD_W(WORD_W)) rx_i (
    .clk(clk), .rstN(rstN), .fsIn(fsIn), .dIn(dIn),
    .rxWord(rxWord), .rxValid(rxValid)
  );

  assign lane0 = laneOut[0];
  assign lane1 = laneOut[1];
endmodule

// File: rtl/serial_pair_port_chk.sv
module serial_pair_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              pairValid,
  input logic              pairReady,
  input logic              singleStream,
  input logic [WORD_W-1:0] aI,
  input logic [WORD_W-1:0] aQ,
  input logic [WORD_W-1:0] bI,
  input logic [WORD_W-1:0] bQ,
  input logic              fsOut,
  input logic              lane0,
  input logic              lane1,
  input logic              overrun,
  input logic              fsIn,
  input logic              dIn,
  input logic [WORD_W-1:0] rxWord,
  input logic              rxValid
);
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    pairValid && pairReady |=> !pairReady && fsOut);  // R2
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fsOut |=> !fsOut);  // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    pairValid && !pairReady |=> overrun);  // R7
  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);  // R7
  AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    pairReady |-> !lane0 && !lane1);  // R8
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);  // R9
endmodule

bind serial_pair_port serial_pair_port_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/serial_pair_port_tb.sv
module serial_pair_port_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pairValid = 1'b0, singleStream = 1'b0;
  logic [W-1:0] aI = '0, aQ = '0, bI = '0, bQ = '0;
  logic fsOut, lane0, lane1, overrun, pairReady, rxValid;
  logic [W-1:0] rxWord;
  logic loopback = 1'b1;
  logic fsDrv = 1'b0, dDrv = 1'b0;
  logic fsIn, dIn;
  int checks = 0, fails = 0;
  logic [W-1:0] rxQ [$];
  bit done = 0;

  assign fsIn = loopback ? fsOut : fsDrv;
  assign dIn  = loopback ? lane0 : dDrv;

  always #4 clk = ~clk;

  serial_pair_port dut_i (
    .clk(clk), .rstN(rstN), .pairValid(pairValid), .pairReady(pairReady),
    .singleStream(singleStream), .aI(aI), .aQ(aQ), .bI(bI), .bQ(bQ),
    .fsOut(fsOut), .lane0(lane0), .lane1(lane1), .overrun(overrun),
    .fsIn(fsIn), .dIn(dIn), .rxWord(rxWord), .rxValid(rxValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compare every received word against the scoreboard queue (R9)
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (rxQ.size() == 0) begin
        check("R9_unexpected_valid", 32'(rxWord), 32'hdead);
      end else begin
        check("R9_rx_word", 32'(rxWord), 32'(rxQ.pop_front()));
      end
    end
  end

  task automatic sendPair(input logic [W-1:0] i0, q0, i1, q1, input logic single, input int pokeAt);
    logic [2*W-1:0] exp0 = {i0, q0};
    logic [2*W-1:0] exp1 = single ? '0 : {i1, q1};
    while (!pairReady) @(negedge clk);
    aI = i0; aQ = q0; bI = i1; bQ = q1; singleStream = single; pairValid = 1'b1;
    rxQ.push_back(i0);
    rxQ.push_back(q0);
    @(negedge clk);
    pairValid = 1'b0;
    check("R3_sync_first", 32'(fsOut), 32'd1);
    check("R2_busy", 32'(pairReady), 32'd0);
    check("R8_sync_lanes", 32'({lane0, lane1}), 32'd0);
    for (int k = 0; k < 2 * W; k++) begin
      @(negedge clk);
      pairValid = 1'b0;
      check("R4_lane0", 32'(lane0), 32'(exp0[2*W-1-k]));
      check(single ? "R6_lane1_zero" : "R5_lane1", 32'(lane1), 32'(exp1[2*W-1-k]));
      check("R3_sync_pos", 32'(fsOut), (k == W - 1) ? 32'd1 : 32'd0);
      check("R2_busy_frame", 32'(pairReady), 32'd0);
      if (k == pokeAt) begin
        aI = ~i0; aQ = ~q0; bI = ~i1; bQ = ~q1; pairValid = 1'b1;
      end
    end
    @(negedge clk);
    check("R2_ready_again", 32'(pairReady), 32'd1);
    check("R8_idle_lanes", 32'({lane0, lane1, fsOut}), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1_reset_outs", 32'({fsOut, lane0, lane1, overrun, rxValid}), 32'd0);
    check("R1_reset_ready", 32'(pairReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    sendPair(16'hA5C3, 16'h0F0F, 16'h1234, 16'hFEDC, 1'b0, -1);
    sendPair(16'h8001, 16'h7FFE, 16'hFFFF, 16'h0000, 1'b0, -1);
    sendPair(16'h3C96, 16'hC369, 16'hFFFF, 16'hFFFF, 1'b1, -1);
    check("R7_no_overrun_yet", 32'(overrun), 32'd0);
    // R10: abandoned partial word, then a full one
    loopback = 1'b0;
    @(negedge clk);
    fsDrv = 1'b1;
    @(negedge clk);
    fsDrv = 1'b0;
    for (int k = 0; k < 5; k++) begin dDrv = 1'b1; @(negedge clk); end
    rxQ.push_back(16'h6B1D);
    fsDrv = 1'b1;
    @(negedge clk);
    fsDrv = 1'b0;
    for (int k = 0; k < W; k++) begin
      dDrv = 16'h6B1D >> (W - 1 - k);
      @(negedge clk);
      if (k == W - 1) check("R10_valid_after_restart", 32'(rxValid), 32'd1);
    end
    dDrv = 1'b0;
    repeat (3) @(negedge clk);
    check("R10_queue_empty", 32'(rxQ.size()), 32'd0);
    loopback = 1'b1;
    @(negedge clk);
    // R7: a pair offered mid-frame is dropped and flagged
    sendPair(16'h5AA5, 16'h9119, 16'h0ACE, 16'hBEEF, 1'b0, 10);
    check("R7_overrun_set", 32'(overrun), 32'd1);
    repeat (40) @(negedge clk);
    check("R7_overrun_sticky", 32'(overrun), 32'd1);
    check("R7_no_extra_frame", 32'(rxQ.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule